// File: doc/BRIEF.md
# Doubled-Word Rotate-and-Mask Unit

This block is the rotate-and-mask datapath of a 64-bit integer core. It runs three 32-bit word rotate operations. Before rotating, the low word of the source operand is copied into both halves of a 64-bit value. That value is rotated left, and the result is then filtered through a mask built from two 5-bit indices. The first operation takes the rotate amount from an immediate field and keeps only the masked bits. The second does the same, but the amount comes from a register operand. The third merges the masked rotated bits into the destination's old value.

The mask indices count bits of the low word from its most significant end. When the begin index is greater than the end index, the mask wraps around. A wrapped mask also covers the whole upper half of the 64-bit result, so copies of the rotated word survive there.

The unit accepts one operation per cycle. It registers the result, which is valid one cycle after the operation is presented. Instruction decode, register-file access and condition flags belong to the surrounding pipeline.

Top module: `rotmask_unit`

## Requirements
- R1: While `rstN` is low, and after it rises with no operation issued, `result` is zero and `outValid` is low.
- R2: Operation codes are 0 (rotate by immediate, then mask), 1 (rotate by register, then mask) and 2 (rotate, then insert under mask). When `inValid` is high with one of these codes, `outValid` is high one cycle later and `result` holds that operation's value.
- R3: The rotate input is the low 32 bits of `srcVal`, placed in both halves of a 64-bit value that is rotated left as a whole. Bits 63..32 of `srcVal` have no effect on the result.
- R4: When `maskBegin` <= `maskEnd`, the mask has ones exactly at big-endian positions 32+`maskBegin` through 32+`maskEnd`. Big-endian position p is little-endian bit 63-p. All other mask bits are zero.
- R5: When `maskBegin` > `maskEnd`, the mask is zero exactly at big-endian positions 33+`maskEnd` through 31+`maskBegin` and one everywhere else, including all of bits 63..32. If `maskBegin` = `maskEnd`+1, the mask is all ones.
- R6: Code 0 gives the rotated value AND the mask, using `shImm` as the amount. Source F7487D82EC6F75DF with shift 5, begin 12 and end 4 gives 8DEEBBFD880EBBFD.
- R7: Code 1 uses only bits 4..0 of `amtReg` as the amount. Source 0000000000000002 with `amtReg` 7FFFFFFFFFFFFFFF, begin 31 and end 16 gives 0000000100000001.
- R8: Code 2 gives (rotated AND mask) OR (`dstVal` AND NOT mask). With source and destination both FFFFFFFFFFFFFFF0, shift 29, begin 14 and end 1, the result is 1FFFFFFE3FFFFFFE.
- R9: Code 2 with begin 31 and end 0 keeps the rotated upper half and only big-endian positions 32 and 63. For source and destination ED7EB4DD824F0853 with shift 10, the result is 3C214E09024F0853.
- R10: For codes 0 and 1 with begin 0 and end 31, the result is the plain 32-bit left rotate of the low word, zero-extended to 64 bits.
- R11: Code 3 is not accepted. `outValid` is low on the next cycle and `result` keeps its previous value.
- R12: While `inValid` is low, `result` keeps its previous value and `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation present this cycle |
| opSel | input | 2 | Operation code (0 immediate, 1 register, 2 insert, 3 none) |
| srcVal | input | 64 | Source operand; only its low word is rotated |
| dstVal | input | 64 | Destination's old value for the insert operation |
| amtReg | input | 64 | Register operand holding the rotate amount in bits 4..0 |
| shImm | input | 5 | Immediate rotate amount |
| maskBegin | input | 5 | Mask begin index (big-endian within the low word) |
| maskEnd | input | 5 | Mask end index (big-endian within the low word) |
| result | output | 64 | Registered result |
| outValid | output | 1 | Result updated by an accepted operation |

## Verification
The bench builds the unit with its default 32-bit word, so the result is 64 bits wide. That brings every pair of begin and end indices within reach, all 1024 of them, covering both the wrapped and the unwrapped masks. Each pair is combined with all 32 rotate amounts, and the three operation codes rotate through the sweep. Expected results come from shift arithmetic on the doubled word and from mask lengths, rather than from per-bit comparisons. The sweep sits alongside the fixed worked vectors, an all-ones-mask case, and source operands whose upper bits are scrambled.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

  typedef enum logic [1:0] {
    OP_ROT_IMM = 2'd0,
    OP_ROT_REG = 2'd1,
    OP_ROT_INS = 2'd2,
    OP_NONE    = 2'd3
  } rm_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new result
    logic useReg;  // amount comes from the register operand
    logic insert;  // merge with the destination under the mask
  } rm_strobe_t;

endpackage

// File: rtl/rotmask_ctrl.sv
module rotmask_ctrl
  import rotmask_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] opSel,
  output rm_strobe_t strobe,
  output logic       outValid
);

  rm_op_e opCode;
  logic   legalOp;

  assign opCode  = rm_op_e'(opSel);
  assign legalOp = (opCode == OP_ROT_IMM) || (opCode == OP_ROT_REG) ||
                   (opCode == OP_ROT_INS);

  always_comb begin
    strobe        = '0;
    strobe.load   = inValid && legalOp;
    strobe.useReg = (opCode == OP_ROT_REG);
    strobe.insert = (opCode == OP_ROT_INS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strobe.load;
  end

  // R2: an accepted operation raises the valid flag next cycle
  p_accept_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel != 2'd3) |=> outValid);

  // R11 / R12: no operation or an illegal code leaves valid low
  p_reject_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid || opSel == 2'd3) |=> !outValid);

endmodule

// File: rtl/rotmask_rot.sv
module rotmask_rot #(
  parameter int WORD_W = 32,
  localparam int DW = 2 * WORD_W,
  localparam int SW = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word,
  input  logic [SW-1:0]     amt,
  output logic [DW-1:0]     rotated
);

  logic [DW-1:0] stage [0:SW];

  assign stage[0] = {word, word};

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int N = 1 << s;
    assign stage[s+1] = amt[s] ? {stage[s][DW-1-N:0], stage[s][DW-1:DW-N]}
                               : stage[s];
  end

  assign rotated = stage[SW];

endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
  parameter int WORD_W = 32,
  localparam int DW = 2 * WORD_W,
  localparam int SW = $clog2(WORD_W)
) (
  input  logic [SW-1:0] beginIdx,
  input  logic [SW-1:0] endIdx,
  output logic [DW-1:0] mask
);

  logic wrapped;
  assign wrapped = beginIdx > endIdx;

  for (genvar k = 0; k < DW; k++) begin : g_bit
    if (k >= WORD_W) begin : g_upper
      // upper half only lives under a wrapped mask
      assign mask[k] = wrapped;
    end else begin : g_lower
      localparam logic [SW-1:0] WB = SW'(WORD_W - 1 - k);
      logic geBegin, leEnd;
      assign geBegin = WB >= beginIdx;
      assign leEnd   = WB <= endIdx;
      assign mask[k] = wrapped ? (geBegin || leEnd) : (geBegin && leEnd);
    end
  end

endmodule

// File: rtl/rotmask_dp.sv
module rotmask_dp
  import rotmask_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int DW = 2 * WORD_W,
  localparam int SW = $clog2(WORD_W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  rm_strobe_t    strobe,
  input  logic [DW-1:0] srcVal,
  input  logic [DW-1:0] dstVal,
  input  logic [DW-1:0] amtReg,
  input  logic [SW-1:0] shImm,
  input  logic [SW-1:0] maskBegin,
  input  logic [SW-1:0] maskEnd,
  output logic [DW-1:0] result
);

  logic [SW-1:0] rotAmt;
  logic [DW-1:0] rotated;
  logic [DW-1:0] mask;
  logic [DW-1:0] merged;
  logic          unusedBits;

  assign unusedBits = ^{srcVal[DW-1:WORD_W], amtReg[DW-1:SW]};

  assign rotAmt = strobe.useReg ? amtReg[SW-1:0] : shImm;

  rotmask_rot #(.WORD_W(WORD_W)) u_rot (
    .word    (srcVal[WORD_W-1:0]),
    .amt     (rotAmt),
    .rotated (rotated)
  );

  rotmask_maskgen #(.WORD_W(WORD_W)) u_mask (
    .beginIdx (maskBegin),
    .endIdx   (maskEnd),
    .mask     (mask)
  );

  always_comb begin
    if (strobe.insert) merged = (rotated & mask) | (dstVal & ~mask);
    else               merged = rotated & mask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            result <= '0;
    else if (strobe.load) result <= merged;
  end

  // R12: result only changes on an accepted operation
  p_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(result));

  // R4 / R5: plain rotates carry nothing outside the mask
  p_outside_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.insert) |=> ((result & ~$past(mask)) == '0));

  // R8: insert keeps destination bits outside the mask
  p_insert_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.insert) |=>
      (((result ^ $past(dstVal)) & ~$past(mask)) == '0));

  // R10: full low-word mask leaves the upper half empty
  p_full_word_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.insert && maskBegin == '0 && maskEnd == SW'(WORD_W-1))
      |=> (result[DW-1:WORD_W] == '0));

endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rotmask_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int DW = 2 * WORD_W,
  localparam int SW = $clog2(WORD_W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [1:0]    opSel,
  input  logic [DW-1:0] srcVal,
  input  logic [DW-1:0] dstVal,
  input  logic [DW-1:0] amtReg,
  input  logic [SW-1:0] shImm,
  input  logic [SW-1:0] maskBegin,
  input  logic [SW-1:0] maskEnd,
  output logic [DW-1:0] result,
  output logic          outValid
);

  rm_strobe_t strobe;

  rotmask_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .strobe   (strobe),
    .outValid (outValid)
  );

  rotmask_dp #(.WORD_W(WORD_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .srcVal    (srcVal),
    .dstVal    (dstVal),
    .amtReg    (amtReg),
    .shImm     (shImm),
    .maskBegin (maskBegin),
    .maskEnd   (maskEnd),
    .result    (result)
  );

endmodule

// File: tb/rotmask_unit_test.sv
`timescale 1ns/1ps
module rotmask_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = 2'd3;
  logic [63:0] srcVal = '0, dstVal = '0, amtReg = '0;
  logic [4:0]  shImm = '0, maskBegin = '0, maskEnd = '0;
  logic [63:0] result;
  logic        outValid;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rotmask_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .srcVal(srcVal), .dstVal(dstVal), .amtReg(amtReg), .shImm(shImm),
    .maskBegin(maskBegin), .maskEnd(maskEnd),
    .result(result), .outValid(outValid)
  );

  function automatic logic [63:0] expRot(input logic [63:0] s, input int amt);
    logic [63:0] d;
    d = {s[31:0], s[31:0]};
    if (amt == 0) return d;
    return (d << amt) | (d >> (64 - amt));
  endfunction

  function automatic logic [63:0] expMask(input int mb, input int me);
    logic [63:0] run;
    if (mb <= me) begin
      run = ((64'd1 << (me - mb + 1)) - 64'd1) << (31 - me);
      return {32'h0, run[31:0]};
    end
    if (mb == me + 1) return '1;
    run = ((64'd1 << (mb - me - 1)) - 64'd1) << (32 - mb);
    return {32'hFFFF_FFFF, ~run[31:0]};
  endfunction

  function automatic logic [63:0] expResult(input int op, input logic [63:0] s,
      input logic [63:0] d, input logic [63:0] a, input int sh, input int mb, input int me);
    logic [63:0] r, m;
    r = expRot(s, (op == 1) ? int'(a[4:0]) : sh);
    m = expMask(mb, me);
    return (op == 2) ? ((r & m) | (d & ~m)) : (r & m);
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input bit v, input logic [1:0] op, input logic [63:0] s,
      input logic [63:0] d, input logic [63:0] a, input int sh, input int mb, input int me);
    @(negedge clk);
    inValid = v; opSel = op; srcVal = s; dstVal = d; amtReg = a;
    shImm = 5'(sh); maskBegin = 5'(mb); maskEnd = 5'(me);
    @(posedge clk);
    #1;
  endtask

  task automatic runOp(input string tag, input int op, input logic [63:0] s,
      input logic [63:0] d, input logic [63:0] a, input int sh, input int mb, input int me);
    issue(1'b1, 2'(op), s, d, a, sh, mb, me);
    check64({tag, " valid"}, {63'd0, outValid}, 64'd1);
    check64(tag, result, expResult(op, s, d, a, sh, mb, me));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [63:0] seed, held, rot32;
    seed = 64'h9E37_79B9_7F4A_7C15;

    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check64("R1 reset result", result, 64'd0);
    check64("R1 reset valid", {63'd0, outValid}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check64("R1 after release result", result, 64'd0);
    check64("R1 after release valid", {63'd0, outValid}, 64'd0);

    // R6 worked vector
    issue(1'b1, 2'd0, 64'hF7487D82EC6F75DF, 64'h0, 64'h0, 5, 12, 4);
    check64("R6 immediate vector", result, 64'h8DEEBBFD880EBBFD);
    check64("R2 valid after op", {63'd0, outValid}, 64'd1);
    // R7 worked vector, upper amount bits set
    issue(1'b1, 2'd1, 64'h2, 64'h0, 64'h7FFFFFFFFFFFFFFF, 0, 31, 16);
    check64("R7 register vector", result, 64'h0000000100000001);
    // R8 worked vector
    issue(1'b1, 2'd2, 64'hFFFFFFFFFFFFFFF0, 64'hFFFFFFFFFFFFFFF0, 64'h0, 29, 14, 1);
    check64("R8 insert vector", result, 64'h1FFFFFFE3FFFFFFE);
    // R9 worked vector
    issue(1'b1, 2'd2, 64'hED7EB4DD824F0853, 64'hED7EB4DD824F0853, 64'h0, 10, 31, 0);
    check64("R9 insert wrap vector", result, 64'h3C214E09024F0853);
    // R5: begin = end+1 gives all ones, insert fully replaced
    issue(1'b1, 2'd2, 64'h0000_0000_1234_5678, 64'hDEAD_BEEF_CAFE_F00D, 64'h0, 4, 9, 8);
    check64("R5 all-ones mask", result, 64'h2345_6781_2345_6781);

    // R3: upper source bits have no effect
    issue(1'b1, 2'd0, 64'hA5A5_5A5A_0F0F_1234, 64'h0, 64'h0, 7, 20, 3);
    held = result;
    issue(1'b1, 2'd0, 64'h0000_0000_0F0F_1234, 64'h0, 64'h0, 7, 20, 3);
    check64("R3 upper source ignored", result, held);

    // R10: full low-word mask equals plain 32-bit rotate
    for (int sh = 0; sh < 32; sh += 5) begin
      rot32 = {32'h0, (seed[31:0] << sh) | (seed[31:0] >> ((32 - sh) % 32))};
      if (sh == 0) rot32 = {32'h0, seed[31:0]};
      issue(1'b1, 2'd0, seed, 64'h0, 64'h0, sh, 0, 31);
      check64("R10 immediate plain rotate", result, rot32);
      issue(1'b1, 2'd1, seed, 64'h0, {59'h5A5A5A5, 5'(sh)}, 0, 0, 31);
      check64("R10 register plain rotate", result, rot32);
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17);
    end

    // R11: illegal code rejected, result held
    held = result;
    issue(1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 3, 0, 31);
    check64("R11 code 3 valid", {63'd0, outValid}, 64'd0);
    check64("R11 code 3 result held", result, held);

    // R12: idle cycles hold result
    for (int i = 0; i < 4; i++) begin
      issue(1'b0, 2'(i % 3), seed, ~seed, seed, i, i, 31 - i);
      check64("R12 idle valid", {63'd0, outValid}, 64'd0);
      check64("R12 idle result held", result, held);
    end

    // R2 R4 R5 R6 R7 R8: sweep every begin/end pair and every amount
    for (int mb = 0; mb < 32; mb++) begin
      for (int me = 0; me < 32; me++) begin
        for (int sh = 0; sh < 32; sh++) begin
          int op;
          logic [63:0] d, a;
          op = (mb + me + sh) % 3;
          d = ~{seed[31:0], seed[63:32]};
          a = {seed[63:5], 5'(sh)};
          runOp((mb <= me) ? "R4 sweep" : "R5 sweep", op, seed, d, a,
                (op == 1) ? int'(seed[9:5]) : sh, mb, me);
          seed = seed ^ (seed << 13); seed = seed ^ (seed >> 7); seed = seed ^ (seed << 17);
        end
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule